// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block runs on the memory controller and takes a DDR3 device from power-on to a state where it can accept normal commands. It drives the memory reset pin, clock enable, on-die termination control and the full command bus (chip select, row/column strobes, write enable, bank address and address). It walks through a fixed series of timed steps, each counted in controller clock cycles. The time limits are given as nanosecond parameters and converted to cycles by rounding up against the clock period parameter. The four mode-register payloads come from static configuration inputs. When every wait has run out, the block raises `init_done` and holds it.

The state machine has fourteen states. `ST_RST_HOLD` keeps the memory in reset and moves to `ST_CKE_WAIT` when its timer runs out. `ST_CKE_WAIT` releases reset but keeps CKE low, and moves to `ST_XPR_WAIT` when its timer runs out. `ST_XPR_WAIT` raises CKE and moves to `ST_LOAD_MR2` at the end of its wait. Each load state lasts one cycle. `ST_LOAD_MR2` is followed by `ST_GAP_MR3`, then `ST_LOAD_MR3`, `ST_GAP_MR1`, `ST_LOAD_MR1`, `ST_GAP_MR0` and `ST_LOAD_MR0`, and each gap state ends when its timer runs out. `ST_LOAD_MR0` moves to `ST_MOD_WAIT`, which is followed by `ST_ZQ_LONG` (one cycle) and then `ST_SETTLE`. `ST_SETTLE` moves to `ST_READY` once the DLL-lock and ZQ-init timers have both expired. `ST_READY` is terminal until reset.

Top module: `ddr3_powerup_seq`

## Requirements
- R1: While `rst_n` is low, `ddr_reset_n`, `ddr_cke` and `init_done` are all 0.
- R2: After reset release, `ddr_reset_n` stays 0 for RST = ceil(RESET_HOLD_NS/period) cycles. `ddr_cke` then stays 0 for a further CK = max(ceil(CKE_DELAY_NS/period), max(ceil(CLK_STABLE_NS/period), CLK_STABLE_MIN_CYC)) cycles, and CKE is never 1 while `ddr_reset_n` is 0.
- R3: In every cycle that issues no command, the bus carries a NOP: CS#/RAS#/CAS#/WE# = 0111, with BA and address at 0. This includes the cycle just before CKE rises.
- R4: Once `ddr_cke` is 1, it stays 1 until reset.
- R5: `ddr_odt` equals the parameter ODT_LEVEL (default 0) in every cycle.
- R6: The first mode-register set comes XPR = max(ceil(TXS_NS/period), TXPR_MIN_CYC) cycles after CKE rises.
- R7: The mode-register sets go out in the order MR2 (BA=3'b010), MR3 (BA=3'b011), MR1 (BA=3'b001), MR0 (BA=3'b000). Consecutive ones are TMRD_CYC cycles apart.
- R8: The MR1 write carries `mr1_cfg` with address bit 0 forced to 0, which enables the DLL.
- R9: The MR0 write carries `mr0_cfg` with address bit 8 forced to 1, which requests a DLL reset.
- R10: ZQCL (CS#/RAS#/CAS#/WE# = 0110, address = 16'h0400, so A10 = 1, BA = 0) is issued MOD = max(ceil(TMOD_NS/period), TMOD_MIN_CYC) cycles after MR0.
- R11: `init_done` rises in cycle max(t_MR0 + TDLLK_CYC, t_ZQCL + TZQINIT_CYC) + 1 and stays 1. The bus carries NOP from then on.
- R12: A mode-register set uses CS#/RAS#/CAS#/WE# = 0000. The address carries the register's configuration input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| mr0_cfg | input | 16 | Static payload for mode register 0 |
| mr1_cfg | input | 16 | Static payload for mode register 1 |
| mr2_cfg | input | 16 | Static payload for mode register 2 |
| mr3_cfg | input | 16 | Static payload for mode register 3 |
| ddr_reset_n | output | 1 | Memory reset, active low |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_odt | output | 1 | On-die termination control, held static |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 3 | Bank address |
| ddr_addr | output | 16 | Address bus |
| init_done | output | 1 | Sequence complete, sticky |

## Verification
The assertions check several properties on every cycle:
- CKE never rises while the memory is in reset, and never drops once it is high.
- The cycle before CKE rises carries a NOP.
- Every MR1 write has the DLL-enable bit cleared, and every MR0 write has the DLL-reset bit set.
- `init_done` is sticky and rises only after both long timers have expired.

Only the bench scenarios can show the exact cycle of each step: the reset and CKE delays, the tXPR maximum, the mode-register order and spacing, the ZQCL offset, and which of the two long waits decides completion. The bench checks these by comparing every output pin, cycle by cycle, against an arithmetic timeline. It does this for two configurations, one where the DLL-lock wait finishes last and one where the ZQ wait finishes last, each with several payload patterns.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    typedef enum logic [3:0] {
        ST_RST_HOLD,
        ST_CKE_WAIT,
        ST_XPR_WAIT,
        ST_LOAD_MR2,
        ST_GAP_MR3,
        ST_LOAD_MR3,
        ST_GAP_MR1,
        ST_LOAD_MR1,
        ST_GAP_MR0,
        ST_LOAD_MR0,
        ST_MOD_WAIT,
        ST_ZQ_LONG,
        ST_SETTLE,
        ST_READY
    } init_state_t;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_MRS,
        BUS_ZQL
    } bus_op_t;

    // CS#, RAS#, CAS#, WE#
    localparam logic [3:0] PINS_NOP  = 4'b0111;
    localparam logic [3:0] PINS_MRS  = 4'b0000;
    localparam logic [3:0] PINS_ZQCL = 4'b0110;

    localparam logic [2:0] BANK_MR0 = 3'b000;
    localparam logic [2:0] BANK_MR1 = 3'b001;
    localparam logic [2:0] BANK_MR2 = 3'b010;
    localparam logic [2:0] BANK_MR3 = 3'b011;

    localparam int DLL_ENABLE_BIT = 0;
    localparam int DLL_RESET_BIT  = 8;
    localparam int ZQ_LONG_BIT    = 10;

    function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                     input longint unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic longint unsigned max2(input longint unsigned a,
                                             input longint unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_interval_timer.sv
module init_interval_timer #(
    parameter int           W          = 8,
    parameter logic [W-1:0] INIT_VAL   = '0,
    parameter bit           INIT_ARMED = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;
    logic         armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= INIT_VAL;
            armed_q <= INIT_ARMED;
        end else if (load) begin
            cnt_q   <= load_val;
            armed_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign expired = armed_q && (cnt_q == '0);

    // R11: once expired, the interval stays expired until reloaded
    p_expiry_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/init_cmd_encoder.sv
module init_cmd_encoder
    import ddr3_init_pkg::*;
#(
    parameter int BA_W   = 3,
    parameter int ADDR_W = 16
) (
    input  bus_op_t           op,
    input  logic [BA_W-1:0]   mrs_ba,
    input  logic [ADDR_W-1:0] mrs_addr,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    logic [3:0] pins;

    always_comb begin
        pins = PINS_NOP;
        ba   = '0;
        addr = '0;
        unique case (op)
            BUS_MRS: begin
                pins = PINS_MRS;
                ba   = mrs_ba;
                addr = mrs_addr;
            end
            BUS_ZQL: begin
                pins              = PINS_ZQCL;
                addr[ZQ_LONG_BIT] = 1'b1;
            end
            default: pins = PINS_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = pins;

endmodule

// File: rtl/ddr3_powerup_seq.sv
module ddr3_powerup_seq
    import ddr3_init_pkg::*;
#(
    parameter longint unsigned CLK_PERIOD_PS      = 1250,
    parameter longint unsigned RESET_HOLD_NS      = 200000,
    parameter longint unsigned CKE_DELAY_NS       = 500000,
    parameter longint unsigned CLK_STABLE_NS      = 10,
    parameter longint unsigned CLK_STABLE_MIN_CYC = 5,
    parameter longint unsigned TXS_NS             = 170,
    parameter longint unsigned TXPR_MIN_CYC       = 5,
    parameter longint unsigned TMRD_CYC           = 4,
    parameter longint unsigned TMOD_NS            = 15,
    parameter longint unsigned TMOD_MIN_CYC       = 12,
    parameter longint unsigned TDLLK_CYC          = 512,
    parameter longint unsigned TZQINIT_CYC        = 512,
    parameter bit              ODT_LEVEL          = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] mr0_cfg,
    input  logic [15:0] mr1_cfg,
    input  logic [15:0] mr2_cfg,
    input  logic [15:0] mr3_cfg,
    output logic        ddr_reset_n,
    output logic        ddr_cke,
    output logic        ddr_odt,
    output logic        ddr_cs_n,
    output logic        ddr_ras_n,
    output logic        ddr_cas_n,
    output logic        ddr_we_n,
    output logic [2:0]  ddr_ba,
    output logic [15:0] ddr_addr,
    output logic        init_done
);

    // Step lengths in cycles
    localparam longint unsigned RST_CYC = max2(ns_to_cycles(RESET_HOLD_NS, CLK_PERIOD_PS), 1);
    localparam longint unsigned CKE_CYC = max2(ns_to_cycles(CKE_DELAY_NS, CLK_PERIOD_PS),
                                   max2(ns_to_cycles(CLK_STABLE_NS, CLK_PERIOD_PS), CLK_STABLE_MIN_CYC));
    localparam longint unsigned XPR_CYC = max2(max2(ns_to_cycles(TXS_NS, CLK_PERIOD_PS), TXPR_MIN_CYC), 1);
    localparam longint unsigned MRD_GAP = max2(TMRD_CYC, 2) - 1;
    localparam longint unsigned MOD_CYC = max2(ns_to_cycles(TMOD_NS, CLK_PERIOD_PS), TMOD_MIN_CYC);
    localparam longint unsigned MOD_GAP = max2(MOD_CYC, 2) - 1;
    localparam longint unsigned STEP_MAX = max2(max2(RST_CYC, CKE_CYC),
                                                max2(max2(XPR_CYC, MRD_GAP), MOD_GAP));
    localparam int STEP_W = $clog2(STEP_MAX + 1);
    localparam longint unsigned LONG_MAX = max2(max2(TDLLK_CYC, TZQINIT_CYC), 1);
    localparam int LONG_W = $clog2(LONG_MAX + 1);

    localparam logic [STEP_W-1:0] RST_LD = STEP_W'(RST_CYC - 1);
    localparam logic [STEP_W-1:0] CKE_LD = STEP_W'(CKE_CYC - 1);
    localparam logic [STEP_W-1:0] XPR_LD = STEP_W'(XPR_CYC - 1);
    localparam logic [STEP_W-1:0] MRD_LD = STEP_W'(MRD_GAP - 1);
    localparam logic [STEP_W-1:0] MOD_LD = STEP_W'(MOD_GAP - 1);
    localparam logic [LONG_W-1:0] DLLK_LD = LONG_W'(max2(TDLLK_CYC, 1) - 1);
    localparam logic [LONG_W-1:0] ZQI_LD  = LONG_W'(max2(TZQINIT_CYC, 1) - 1);

    init_state_t       state_q, state_d;
    logic              step_load;
    logic [STEP_W-1:0] step_val;
    logic              step_exp, dllk_exp, zqi_exp;
    bus_op_t           bus_op;
    logic [2:0]        mrs_ba;
    logic [15:0]       mrs_addr;

    init_interval_timer #(.W(STEP_W), .INIT_VAL(RST_LD), .INIT_ARMED(1'b1)) i_step_timer (
        .clk(clk), .rst_n(rst_n), .load(step_load), .load_val(step_val), .expired(step_exp)
    );

    init_interval_timer #(.W(LONG_W), .INIT_VAL('0), .INIT_ARMED(1'b0)) i_dllk_timer (
        .clk(clk), .rst_n(rst_n), .load(state_q == ST_LOAD_MR0), .load_val(DLLK_LD),
        .expired(dllk_exp)
    );

    init_interval_timer #(.W(LONG_W), .INIT_VAL('0), .INIT_ARMED(1'b0)) i_zqi_timer (
        .clk(clk), .rst_n(rst_n), .load(state_q == ST_ZQ_LONG), .load_val(ZQI_LD),
        .expired(zqi_exp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RST_HOLD;
        else        state_q <= state_d;
    end

    // Transitions and step-timer loads
    always_comb begin
        state_d   = state_q;
        step_load = 1'b0;
        step_val  = '0;
        unique case (state_q)
            ST_RST_HOLD: if (step_exp) begin
                state_d = ST_CKE_WAIT; step_load = 1'b1; step_val = CKE_LD;
            end
            ST_CKE_WAIT: if (step_exp) begin
                state_d = ST_XPR_WAIT; step_load = 1'b1; step_val = XPR_LD;
            end
            ST_XPR_WAIT: if (step_exp) state_d = ST_LOAD_MR2;
            ST_LOAD_MR2: begin
                state_d = ST_GAP_MR3; step_load = 1'b1; step_val = MRD_LD;
            end
            ST_GAP_MR3:  if (step_exp) state_d = ST_LOAD_MR3;
            ST_LOAD_MR3: begin
                state_d = ST_GAP_MR1; step_load = 1'b1; step_val = MRD_LD;
            end
            ST_GAP_MR1:  if (step_exp) state_d = ST_LOAD_MR1;
            ST_LOAD_MR1: begin
                state_d = ST_GAP_MR0; step_load = 1'b1; step_val = MRD_LD;
            end
            ST_GAP_MR0:  if (step_exp) state_d = ST_LOAD_MR0;
            ST_LOAD_MR0: begin
                state_d = ST_MOD_WAIT; step_load = 1'b1; step_val = MOD_LD;
            end
            ST_MOD_WAIT: if (step_exp) state_d = ST_ZQ_LONG;
            ST_ZQ_LONG:  state_d = ST_SETTLE;
            ST_SETTLE:   if (dllk_exp && zqi_exp) state_d = ST_READY;
            ST_READY:    state_d = ST_READY;
            default:     state_d = ST_RST_HOLD;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        ddr_reset_n = 1'b1;
        ddr_cke     = 1'b1;
        init_done   = 1'b0;
        bus_op      = BUS_IDLE;
        mrs_ba      = '0;
        mrs_addr    = '0;
        unique case (state_q)
            ST_RST_HOLD: begin ddr_reset_n = 1'b0; ddr_cke = 1'b0; end
            ST_CKE_WAIT: ddr_cke = 1'b0;
            ST_LOAD_MR2: begin bus_op = BUS_MRS; mrs_ba = BANK_MR2; mrs_addr = mr2_cfg; end
            ST_LOAD_MR3: begin bus_op = BUS_MRS; mrs_ba = BANK_MR3; mrs_addr = mr3_cfg; end
            ST_LOAD_MR1: begin
                bus_op = BUS_MRS; mrs_ba = BANK_MR1; mrs_addr = mr1_cfg;
                mrs_addr[DLL_ENABLE_BIT] = 1'b0;
            end
            ST_LOAD_MR0: begin
                bus_op = BUS_MRS; mrs_ba = BANK_MR0; mrs_addr = mr0_cfg;
                mrs_addr[DLL_RESET_BIT] = 1'b1;
            end
            ST_ZQ_LONG:  bus_op = BUS_ZQL;
            ST_READY:    init_done = 1'b1;
            default:     bus_op = BUS_IDLE;
        endcase
    end

    assign ddr_odt = ODT_LEVEL;

    init_cmd_encoder #(.BA_W(3), .ADDR_W(16)) i_cmd_encoder (
        .op(bus_op), .mrs_ba(mrs_ba), .mrs_addr(mrs_addr),
        .cs_n(ddr_cs_n), .ras_n(ddr_ras_n), .cas_n(ddr_cas_n), .we_n(ddr_we_n),
        .ba(ddr_ba), .addr(ddr_addr)
    );

    logic pins_mrs, pins_nop;
    assign pins_mrs = ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == PINS_MRS);
    assign pins_nop = ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == PINS_NOP);

    p_cke_after_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |-> ddr_reset_n);

    p_nop_before_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ddr_cke) |-> $past(pins_nop));

    p_cke_stays_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |=> ddr_cke);

    p_dll_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_mrs && ddr_ba == BANK_MR1) |-> !ddr_addr[DLL_ENABLE_BIT]);

    p_dll_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_mrs && ddr_ba == BANK_MR0) |-> ddr_addr[DLL_RESET_BIT]);

    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_done_after_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(dllk_exp && zqi_exp));

endmodule

// File: tb/test_ddr3_powerup_seq.sv
module test_ddr3_powerup_seq;

    localparam longint PER_PS = 10000;

    // Configuration A: DLL-lock wait finishes last
    localparam longint A_RST_NS = 200, A_CKE_NS = 500, A_TXS_NS = 30, A_MRD = 4;
    localparam longint A_MOD_NS = 15, A_DLLK = 40, A_ZQI = 25;
    // Configuration B: ZQ wait finishes last, clock-stable and tXS terms dominate
    localparam longint B_RST_NS = 100, B_CKE_NS = 20, B_TXS_NS = 120, B_MRD = 2;
    localparam longint B_MOD_NS = 200, B_DLLK = 10, B_ZQI = 30;

    localparam int T_END = 140;

    function automatic int cdiv(input longint ns);
        return int'((ns * 1000 + PER_PS - 1) / PER_PS);
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst_n = 1'b0;
    logic [15:0] mr0, mr1, mr2, mr3;

    logic a_rst, a_cke, a_odt, a_cs, a_ras, a_cas, a_we, a_done;
    logic [2:0] a_ba;  logic [15:0] a_addr;
    logic b_rst, b_cke, b_odt, b_cs, b_ras, b_cas, b_we, b_done;
    logic [2:0] b_ba;  logic [15:0] b_addr;

    ddr3_powerup_seq #(
        .CLK_PERIOD_PS(PER_PS), .RESET_HOLD_NS(A_RST_NS), .CKE_DELAY_NS(A_CKE_NS),
        .TXS_NS(A_TXS_NS), .TMRD_CYC(A_MRD), .TMOD_NS(A_MOD_NS),
        .TDLLK_CYC(A_DLLK), .TZQINIT_CYC(A_ZQI), .ODT_LEVEL(1'b0)
    ) i_ddr3_powerup_seq (
        .clk(clk), .rst_n(rst_n), .mr0_cfg(mr0), .mr1_cfg(mr1), .mr2_cfg(mr2), .mr3_cfg(mr3),
        .ddr_reset_n(a_rst), .ddr_cke(a_cke), .ddr_odt(a_odt), .ddr_cs_n(a_cs),
        .ddr_ras_n(a_ras), .ddr_cas_n(a_cas), .ddr_we_n(a_we), .ddr_ba(a_ba),
        .ddr_addr(a_addr), .init_done(a_done)
    );

    ddr3_powerup_seq #(
        .CLK_PERIOD_PS(PER_PS), .RESET_HOLD_NS(B_RST_NS), .CKE_DELAY_NS(B_CKE_NS),
        .TXS_NS(B_TXS_NS), .TMRD_CYC(B_MRD), .TMOD_NS(B_MOD_NS),
        .TDLLK_CYC(B_DLLK), .TZQINIT_CYC(B_ZQI), .ODT_LEVEL(1'b1)
    ) i_ddr3_powerup_seq_b (
        .clk(clk), .rst_n(rst_n), .mr0_cfg(mr0), .mr1_cfg(mr1), .mr2_cfg(mr2), .mr3_cfg(mr3),
        .ddr_reset_n(b_rst), .ddr_cke(b_cke), .ddr_odt(b_odt), .ddr_cs_n(b_cs),
        .ddr_ras_n(b_ras), .ddr_cas_n(b_cas), .ddr_we_n(b_we), .ddr_ba(b_ba),
        .ddr_addr(b_addr), .init_done(b_done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input string who, input int t,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: got %h expected %h", tag, who, t, got, exp);
        end
    endtask

    // Expected pin values from the timeline: {rst,cke,odt,cmd[3:0],ba[2:0],addr[15:0],done}
    task automatic check_cycle(input string who, input int t, input logic [26:0] got,
                               input int rst_c, input int cke_c, input int xpr_c,
                               input int mrd, input int mod_c, input int dllk,
                               input int zqi, input logic odt);
        int t_cke, t_mr2, t_mr3, t_mr1, t_mr0, t_zq, t_done;
        logic [3:0] cmd; logic [2:0] ba; logic [15:0] addr;
        string ctag, atag;
        t_cke  = rst_c + cke_c;
        t_mr2  = t_cke + xpr_c;
        t_mr3  = t_mr2 + mrd;
        t_mr1  = t_mr3 + mrd;
        t_mr0  = t_mr1 + mrd;
        t_zq   = t_mr0 + mod_c;
        t_done = imax(t_mr0 + dllk, t_zq + zqi) + 1;
        cmd = 4'b0111; ba = 3'b000; addr = 16'h0000; ctag = "R3"; atag = "R3";
        if (t == t_mr2) begin cmd = 4'b0000; ba = 3'b010; addr = mr2; ctag = "R6"; atag = "R12"; end
        if (t == t_mr3) begin cmd = 4'b0000; ba = 3'b011; addr = mr3; ctag = "R7"; atag = "R12"; end
        if (t == t_mr1) begin cmd = 4'b0000; ba = 3'b001; addr = mr1 & 16'hFFFE; ctag = "R7"; atag = "R8"; end
        if (t == t_mr0) begin cmd = 4'b0000; ba = 3'b000; addr = mr0 | 16'h0100; ctag = "R7"; atag = "R9"; end
        if (t == t_zq)  begin cmd = 4'b0110; ba = 3'b000; addr = 16'h0400; ctag = "R10"; atag = "R10"; end
        chk("R2", who, t, 32'(got[26]), 32'(t >= rst_c));
        chk((t < t_cke) ? "R2" : "R4", who, t, 32'(got[25]), 32'(t >= t_cke));
        chk("R5", who, t, 32'(got[24]), 32'(odt));
        chk(ctag, who, t, 32'(got[23:20]), 32'(cmd));
        chk(ctag, who, t, 32'(got[19:17]), 32'(ba));
        chk(atag, who, t, 32'(got[16:1]), 32'(addr));
        chk("R11", who, t, 32'(got[0]), 32'(t >= t_done));
    endtask

    logic [15:0] bases [3] = '{16'hFFFF, 16'h0000, 16'h5A3C};
    bit finished = 1'b0;

    initial begin
        for (int p = 0; p < 3; p++) begin
            rst_n = 1'b0;
            mr0 = bases[p];
            mr1 = bases[p] ^ 16'h1111;
            mr2 = bases[p] ^ 16'h2222;
            mr3 = bases[p] ^ 16'h3333;
            repeat (3) @(negedge clk);
            #1;
            // R1: reset state
            chk("R1", "A", -1, 32'({a_rst, a_cke, a_done}), 32'h0);
            chk("R1", "B", -1, 32'({b_rst, b_cke, b_done}), 32'h0);
            @(negedge clk);
            rst_n = 1'b1;
            for (int t = 0; t <= T_END; t++) begin
                #1;
                check_cycle("A", t, {a_rst, a_cke, a_odt, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done},
                            cdiv(A_RST_NS), imax(cdiv(A_CKE_NS), imax(cdiv(10), 5)),
                            imax(cdiv(A_TXS_NS), 5), int'(A_MRD), imax(cdiv(A_MOD_NS), 12),
                            int'(A_DLLK), int'(A_ZQI), 1'b0);
                check_cycle("B", t, {b_rst, b_cke, b_odt, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done},
                            cdiv(B_RST_NS), imax(cdiv(B_CKE_NS), imax(cdiv(10), 5)),
                            imax(cdiv(B_TXS_NS), 5), int'(B_MRD), imax(cdiv(B_MOD_NS), 12),
                            int'(B_DLLK), int'(B_ZQI), 1'b1);
                @(negedge clk);
            end
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(2_000_000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule